// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a memory-mapped watchdog. A prescaler divides the slow clock the block runs on down to a tick. The default division is 128, which gives 256 Hz from a 32.768 kHz clock. A 12-bit counter counts down on each tick. When the counter passes zero, the block raises a fault and, if enabled, a one-cycle reset request. It then reloads and keeps running. Software keeps the system alive by sending a restart command, which is protected by a key, to the control word.

The configuration word can be written once after reset. Any later write is ignored. It sets the reload value, the restart window, reset enable, a disable bit and freezing during debug halt. A restart is accepted only while the counter is at or below the window value. A restart sent too early is refused and is recorded as a fault of its own. Two sticky flags hold the reason for a fault, and reading the status word clears them.

Top module: `wdt_window`

## Requirements
- R1: While running, the 12-bit counter steps down by one once every PRESCALE clock cycles (default 128). The prescaler restarts from zero on every reload.
- R2: After a reload with value V in bits 11:0 of the config word, underflow occurs PRESCALE*(V+1) cycles later. If bit 13 is set, rstOut is high for exactly one cycle at that point. The counter then reloads V and keeps counting.
- R3: The config word (address 1) is accepted on its first write after reset, and this write also reloads the counter. Every later write is ignored, and the value read back stays the first value written.
- R4: A write to address 0 with 0xA5 in bits 31:24 and bit 0 set restarts the counter: it reloads V and restarts the prescaler. A write with any other key has no effect.
- R5: A keyed restart is refused while the counter is above the window value in bits 27:16. A refused restart does not reload, sets status bit 1 and raises faultOut.
- R6: When bit 15 (disable) is set, the counter and prescaler stop, no fault or reset occurs, and keyed restarts are ignored.
- R7: When bit 28 is set, counting freezes on every cycle that dbgHalt is high. When bit 28 is clear, dbgHalt is ignored.
- R8: Status (address 2) holds a sticky underflow flag in bit 0 and a sticky refused-restart flag in bit 1. Reading the status word clears both flags. faultOut is the OR of the two flags. Read data appears on the cycle after busRdEn.
- R9: After reset, the config word reads 0x0FFF2FFF, status reads 0, and faultOut and rstOut are low.
- R10: When bit 13 is clear, underflow still sets the status flag and faultOut, but rstOut stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock that drives all logic |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 2 | Word address: 0 control, 1 config, 2 status |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| dbgHalt | input | 1 | Processor is halted in debug |
| faultOut | output | 1 | Underflow or refused restart pending |
| rstOut | output | 1 | One-cycle reset request on underflow |

## Verification
The embedded assertions check on every cycle that the counter only holds or steps down by one between reloads, and that it holds still while stopped or halted. They also check that the config word cannot change once it is locked, that rstOut is a single-cycle pulse which needs reset enable, and that an underflow always leaves the fault flag set. Only the bench scenarios can show the exact timeout length for each reload value. The same holds for whether each restart position falls inside or outside each window setting, the effect of a bad key, the effect of a halt on timing, and the flag clearing when status is read.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 12;
  localparam int BUS_W = 32;
  localparam logic [7:0] RESTART_KEY = 8'hA5;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [BUS_W-1:0] MODE_MASK = 32'h1FFF_AFFF;
  localparam logic [BUS_W-1:0] MODE_RESET = 32'h0FFF_2FFF;
  localparam int BIT_RSTEN = 13;
  localparam int BIT_DIS = 15;
  localparam int BIT_HALT = 28;

  typedef struct packed {
    logic             reload;
    logic             run;
    logic [CNT_W-1:0] reloadVal;
    logic [CNT_W-1:0] window;
  } dpCmd_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int PRESCALE = 128
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCmd_t cmd,
  output logic   underflowEv,
  output logic   inWindow
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [PW-1:0]    presc;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick        = cmd.run && (presc == PLAST);
  assign underflowEv = tick && (cnt == '0) && !cmd.reload;
  assign inWindow    = (cnt <= cmd.window);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc <= '0;
      cnt   <= '1;
    end else if (cmd.reload) begin
      presc <= '0;
      cnt   <= cmd.reloadVal;
    end else if (cmd.run) begin
      presc <= tick ? '0 : presc + 1'b1;
      if (tick) cnt <= (cnt == '0) ? cmd.reloadVal : cnt - 1'b1;
    end
  end

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.reload) |=> $stable(cnt));  // R6 R7

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.reload && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));  // R1
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [1:0]       busAddr,
  input  logic [BUS_W-1:0] busWrData,
  output logic [BUS_W-1:0] busRdData,
  input  logic             dbgHalt,
  input  logic             underflowEv,
  input  logic             inWindow,
  output dpCmd_t           cmd,
  output logic             faultOut,
  output logic             rstOut
);
  logic [BUS_W-1:0] modeReg;
  logic             locked;
  logic             undFlag, errFlag;
  logic             modeWr, restartReq, restartOk, errSet, statRead;
  logic             disabled;
  logic             unusedCtrlBits;

  assign unusedCtrlBits = ^busWrData[23:1];
  assign disabled   = modeReg[BIT_DIS];
  assign modeWr     = busWrEn && (busAddr == ADDR_MODE) && !locked;
  assign restartReq = busWrEn && (busAddr == ADDR_CTRL) && !disabled
                   && (busWrData[31:24] == RESTART_KEY) && busWrData[0];
  assign restartOk  = restartReq && inWindow;
  assign errSet     = restartReq && !inWindow;
  assign statRead   = busRdEn && (busAddr == ADDR_STAT);

  always_comb begin
    cmd.reload    = modeWr || restartOk;
    cmd.reloadVal = modeWr ? busWrData[CNT_W-1:0] : modeReg[CNT_W-1:0];
    cmd.window    = modeReg[16 +: CNT_W];
    cmd.run       = !disabled && !(modeReg[BIT_HALT] && dbgHalt);
  end

  assign faultOut = undFlag || errFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg   <= MODE_RESET;
      locked    <= 1'b0;
      undFlag   <= 1'b0;
      errFlag   <= 1'b0;
      rstOut    <= 1'b0;
      busRdData <= '0;
    end else begin
      if (modeWr) begin
        modeReg <= busWrData & MODE_MASK;
        locked  <= 1'b1;
      end
      rstOut <= underflowEv && modeReg[BIT_RSTEN];
      if (underflowEv)   undFlag <= 1'b1;
      else if (statRead) undFlag <= 1'b0;
      if (errSet)        errFlag <= 1'b1;
      else if (statRead) errFlag <= 1'b0;
      if (busRdEn) begin
        unique case (busAddr)
          ADDR_MODE: busRdData <= modeReg;
          ADDR_STAT: busRdData <= {30'd0, errFlag, undFlag};
          default:   busRdData <= '0;
        endcase
      end
    end
  end

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(modeReg));  // R3

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rstOut |=> !rstOut);  // R2

  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    rstOut |-> $past(modeReg[BIT_RSTEN]));  // R10

  AST_UNDERFLOW_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    underflowEv |=> faultOut);  // R8
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
#(
  parameter int PRESCALE = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        dbgHalt,
  output logic        faultOut,
  output logic        rstOut
);
  dpCmd_t cmd;
  logic   underflowEv;
  logic   inWindow;

  wdt_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .dbgHalt(dbgHalt), .underflowEv(underflowEv), .inWindow(inWindow),
    .cmd(cmd), .faultOut(faultOut), .rstOut(rstOut)
  );

  wdt_datapath #(.PRESCALE(PRESCALE)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .underflowEv(underflowEv), .inWindow(inWindow)
  );
endmodule

// File: tb/test_wdt_window.sv
module test_wdt_window;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        dbgHalt = 1'b0;
  logic        faultOut, rstOut;
  int total = 0, bad = 0;
  bit finished = 0;

  wdt_window #(.PRESCALE(P)) i_wdt_window (.*);

  always #4 clk = ~clk;

  function automatic logic [31:0] mk(int v, int d, bit ren, bit dis, bit halt);
    return {3'b0, halt, 12'(d), dis, 1'b0, ren, 1'b0, 12'(v)};
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; dbgHalt = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    @(negedge clk);
    d = busRdData;
  endtask

  task automatic waitHit(bit useFault, int startJ, output int hitJ);
    int j = startJ;
    hitJ = -1;
    while (j < 600) begin
      @(negedge clk);
      j++;
      if (useFault ? faultOut : rstOut) begin
        hitJ = j;
        break;
      end
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hit;
    doReset();
    @(negedge clk);
    check(faultOut == 0 && rstOut == 0, "R9 outputs", {faultOut, rstOut}, 0);
    rd(2'd1, d); check(d == 32'h0FFF2FFF, "R9 mode", d, 32'h0FFF2FFF);
    rd(2'd2, d); check(d == 0, "R9 status", d, 0);

    // R1 R2 timeout sweep, two consecutive periods
    for (int v = 0; v < 8; v++) begin
      doReset();
      wr(2'd1, mk(v, 12'hFFF, 1, 0, 0));
      waitHit(0, 0, hit);
      check(hit == P * (v + 1), "R1 R2 first timeout", hit, P * (v + 1));
      @(negedge clk);
      check(rstOut == 0, "R2 single pulse", rstOut, 0);
      check(faultOut == 1, "R8 fault after underflow", faultOut, 1);
      waitHit(0, hit + 1, hit);
      check(hit == 2 * P * (v + 1), "R2 reload period", hit, 2 * P * (v + 1));
      rd(2'd2, d); check(d == 1, "R8 status underflow", d, 1);
      check(faultOut == 0, "R8 cleared by read", faultOut, 0);
      rd(2'd2, d); check(d == 0, "R8 status clear", d, 0);
    end

    // R5 window sweep: restart at count 7-k with window dw
    for (int dw = 0; dw < 8; dw++) begin
      for (int k = 0; k < 8; k++) begin
        bit expErr;
        expErr = (7 - k) > dw;
        doReset();
        wr(2'd1, mk(7, dw, 1, 0, 0));
        repeat (P * k) @(negedge clk);
        wr(2'd0, 32'hA500_0001);
        check(faultOut == expErr, "R5 fault on early restart", faultOut, expErr);
        rd(2'd2, d);
        check(d == {30'd0, expErr, 1'b0}, "R5 window status", d, {30'd0, expErr, 1'b0});
      end
    end

    // R4 accepted restart delays underflow
    doReset();
    wr(2'd1, mk(7, 12'hFFF, 1, 0, 0));
    repeat (20) @(negedge clk);
    wr(2'd0, 32'hA500_0001);
    waitHit(0, 21, hit);
    check(hit == 21 + 8 * P, "R4 restart reloads", hit, 21 + 8 * P);

    // R4 wrong key ignored
    doReset();
    wr(2'd1, mk(7, 12'hFFF, 1, 0, 0));
    repeat (20) @(negedge clk);
    wr(2'd0, 32'h5A00_0001);
    waitHit(0, 21, hit);
    check(hit == 8 * P, "R4 bad key no effect", hit, 8 * P);

    // R3 second config write ignored
    doReset();
    wr(2'd1, mk(3, 12'hFFF, 1, 0, 0));
    wr(2'd1, mk(7, 12'h005, 0, 1, 1));
    waitHit(0, 1, hit);
    check(hit == 4 * P, "R3 first value timing", hit, 4 * P);
    rd(2'd1, d);
    check(d == mk(3, 12'hFFF, 1, 0, 0), "R3 readback", d, mk(3, 12'hFFF, 1, 0, 0));

    // R6 disable
    doReset();
    wr(2'd1, mk(1, 12'hFFF, 1, 1, 0));
    wr(2'd0, 32'hA500_0001);
    waitHit(1, 1, hit);
    check(hit == -1, "R6 no fault while disabled", hit, -1);
    rd(2'd2, d); check(d == 0, "R6 status clean", d, 0);

    // R7 debug halt freezes counting
    doReset();
    wr(2'd1, mk(3, 12'hFFF, 1, 0, 1));
    dbgHalt = 1'b1;
    repeat (10) @(negedge clk);
    dbgHalt = 1'b0;
    waitHit(0, 10, hit);
    check(hit == 4 * P + 10, "R7 halt extends timeout", hit, 4 * P + 10);

    // R7 halt ignored when bit clear
    doReset();
    wr(2'd1, mk(3, 12'hFFF, 1, 0, 0));
    dbgHalt = 1'b1;
    waitHit(0, 0, hit);
    dbgHalt = 1'b0;
    check(hit == 4 * P, "R7 halt ignored", hit, 4 * P);

    // R10 no reset request when disabled in config
    doReset();
    wr(2'd1, mk(2, 12'hFFF, 0, 0, 0));
    waitHit(1, 0, hit);
    check(hit == 3 * P, "R10 fault timing", hit, 3 * P);
    waitHit(0, hit, hit);
    check(hit == -1, "R10 no rstOut", hit, -1);
    rd(2'd2, d); check(d[0] == 1'b1, "R10 underflow flag", d, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule